// File: doc/BRIEF.md
# Buffer Read Streamer with Destination Select

This block drives the read side of a unified on-chip buffer. It moves a rectangular block of words out of the buffer and delivers it to exactly one of six consumers. The consumers are the left input of the matrix array, the bias stage, the target-value port, the activation-derivative port, and two weight-update ports (one for biases, one for weights).

A single-cycle start pulse captures four fields: a base address, a row count, a column count and a 3-bit destination code. The block then walks the block in row-major order and issues one buffer address per cycle. The buffer answers one cycle later. The block forwards each returned word, with a valid flag, to the consumer named by the captured code. Every other consumer port sees valid low and data zero.

While a transfer is running, the block ignores new starts and changes on the field inputs.

Top module: `buf_read_streamer`

## Requirements
- R1: After reset, busy, done, the buffer read strobe and all six consumer valid outputs are low.
- R2: A start accepted while idle issues base address in the following cycle. One address is issued per cycle after that, each one more than the last, modulo 2^ADDR_W, for rows × columns addresses in total.
- R3: A consumer valid is high exactly in the cycle after each issued address. In that cycle the consumer data equals the buffer word at that address.
- R4: The destination codes are: 0 for the left array input, 2 for bias, 3 for target, 4 for activation-derivative, 5 for bias update and 6 for weight update. Only the selected port's valid is ever high. Unselected ports hold data at zero.
- R5: Codes 1 and 7 select no port. The transfer still runs to completion and produces done, but no consumer valid rises.
- R6: Busy is high from the cycle after an accepted start through the cycle carrying the last valid word. Done is high for exactly the one following cycle, with busy low.
- R7: A start raised while busy is ignored. The running transfer keeps its address sequence, length and destination.
- R8: Base, sizes and destination are captured at start. Changing those inputs during a transfer does not alter it.
- R9: A start with zero rows or zero columns issues no reads and keeps busy low. It raises done in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Launch a transfer (honoured only when idle) |
| base_addr_i | input | ADDR_W | First buffer address of the block |
| rows_i | input | ROW_W | Number of rows |
| cols_i | input | COL_W | Number of columns |
| dest_i | input | 3 | Destination code |
| mem_rd_o | output | 1 | Buffer read strobe |
| mem_addr_o | output | ADDR_W | Buffer read address |
| mem_data_i | input | DATA_W | Buffer read data, one cycle after the strobe |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| left_valid_o | output | 1 | Word valid for the array left input |
| left_data_o | output | DATA_W | Word for the array left input |
| bias_valid_o | output | 1 | Word valid for the bias stage |
| bias_data_o | output | DATA_W | Word for the bias stage |
| target_valid_o | output | 1 | Word valid for the target port |
| target_data_o | output | DATA_W | Word for the target port |
| deriv_valid_o | output | 1 | Word valid for the activation-derivative port |
| deriv_data_o | output | DATA_W | Word for the activation-derivative port |
| bupd_valid_o | output | 1 | Word valid for the bias update port |
| bupd_data_o | output | DATA_W | Word for the bias update port |
| wupd_valid_o | output | 1 | Word valid for the weight update port |
| wupd_data_o | output | DATA_W | Word for the weight update port |

## Verification
The hardest case to reach from the ports is a second start that arrives mid-transfer while the field inputs change under a running block. A correct design must leave no trace of that event. The stimulus drives a fresh start with random fields in the first busy cycle and scrambles the fields right after every launch. The bench then checks the word count, the data order and the destination against the captured values only. Directed runs add a block that wraps past the top of the address space, the two unmapped codes and both zero-size shapes.

// File: rtl/rs_pkg.sv
package rs_pkg;

    localparam int NUM_PORTS = 6;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ISSUE = 2'd1,
        PH_DRAIN = 2'd2
    } rs_phase_e;

    // destination code served by consumer port index p (0 = left input)
    function automatic logic [2:0] port_code(input int p);
        return (p == 0) ? 3'd0 : 3'(p + 1);
    endfunction

endpackage

// File: rtl/rs_walker.sv
module rs_walker #(
    parameter int ADDR_W = 8,
    parameter int ROW_W  = 4,
    parameter int COL_W  = 4
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ROW_W-1:0]  row_i,
    input  logic [ROW_W-1:0]  rows_i,
    input  logic [COL_W-1:0]  col_i,
    input  logic [COL_W-1:0]  cols_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [ROW_W-1:0]  row_o,
    output logic [COL_W-1:0]  col_o,
    output logic              last_o
);
    logic row_end;
    logic col_end;

    always_comb begin
        col_end = (col_i == cols_i - COL_W'(1));
        row_end = (row_i == rows_i - ROW_W'(1));
        last_o  = col_end && row_end;
        addr_o  = addr_i + ADDR_W'(1);
        if (col_end) begin
            col_o = '0;
            row_o = row_i + ROW_W'(1);
        end else begin
            col_o = col_i + COL_W'(1);
            row_o = row_i;
        end
    end
endmodule

// File: rtl/rs_dest_decode.sv
module rs_dest_decode
    import rs_pkg::*;
(
    input  logic [2:0]           code_i,
    output logic [NUM_PORTS-1:0] hot_o
);
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        assign hot_o[p] = (code_i == port_code(p));
    end
endmodule

// File: rtl/rs_route.sv
module rs_route
    import rs_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                              vld_i,
    input  logic [DATA_W-1:0]                 data_i,
    input  logic [NUM_PORTS-1:0]              hot_i,
    output logic [NUM_PORTS-1:0]              vld_o,
    output logic [NUM_PORTS-1:0][DATA_W-1:0]  data_o
);
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        assign vld_o[p]  = vld_i & hot_i[p];
        assign data_o[p] = hot_i[p] ? data_i : '0;
    end
endmodule

// File: rtl/buf_read_streamer.sv
module buf_read_streamer
    import rs_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int ROW_W  = 4,
    parameter int COL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_addr_i,
    input  logic [ROW_W-1:0]  rows_i,
    input  logic [COL_W-1:0]  cols_i,
    input  logic [2:0]        dest_i,
    output logic              mem_rd_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [DATA_W-1:0] mem_data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              left_valid_o,
    output logic [DATA_W-1:0] left_data_o,
    output logic              bias_valid_o,
    output logic [DATA_W-1:0] bias_data_o,
    output logic              target_valid_o,
    output logic [DATA_W-1:0] target_data_o,
    output logic              deriv_valid_o,
    output logic [DATA_W-1:0] deriv_data_o,
    output logic              bupd_valid_o,
    output logic [DATA_W-1:0] bupd_data_o,
    output logic              wupd_valid_o,
    output logic [DATA_W-1:0] wupd_data_o
);
    typedef struct packed {
        rs_phase_e         phase;
        logic [ADDR_W-1:0] addr;
        logic [ROW_W-1:0]  row;
        logic [ROW_W-1:0]  rows;
        logic [COL_W-1:0]  col;
        logic [COL_W-1:0]  cols;
        logic [2:0]        dest;
        logic              vld;
        logic              done;
    } st_t;

    st_t st_d, st_q;

    logic [ADDR_W-1:0] nxt_addr;
    logic [ROW_W-1:0]  nxt_row;
    logic [COL_W-1:0]  nxt_col;
    logic              at_last;

    logic [NUM_PORTS-1:0]             hot;
    logic [NUM_PORTS-1:0]             vld_vec;
    logic [NUM_PORTS-1:0][DATA_W-1:0] dat_vec;

    rs_walker #(.ADDR_W(ADDR_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_walk (
        .addr_i (st_q.addr),
        .row_i  (st_q.row),
        .rows_i (st_q.rows),
        .col_i  (st_q.col),
        .cols_i (st_q.cols),
        .addr_o (nxt_addr),
        .row_o  (nxt_row),
        .col_o  (nxt_col),
        .last_o (at_last)
    );

    always_comb begin
        st_d      = st_q;
        st_d.vld  = 1'b0;
        st_d.done = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    if (rows_i == '0 || cols_i == '0) begin
                        st_d.done = 1'b1;
                    end else begin
                        st_d.phase = PH_ISSUE;
                        st_d.addr  = base_addr_i;
                        st_d.row   = '0;
                        st_d.col   = '0;
                        st_d.rows  = rows_i;
                        st_d.cols  = cols_i;
                        st_d.dest  = dest_i;
                    end
                end
            end
            PH_ISSUE: begin
                st_d.vld  = 1'b1;
                st_d.addr = nxt_addr;
                st_d.row  = nxt_row;
                st_d.col  = nxt_col;
                if (at_last) begin
                    st_d.phase = PH_DRAIN;
                end
            end
            PH_DRAIN: begin
                st_d.phase = PH_IDLE;
                st_d.done  = 1'b1;
            end
            default: begin
                st_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    rs_dest_decode u_dec (
        .code_i (st_q.dest),
        .hot_o  (hot)
    );

    rs_route #(.DATA_W(DATA_W)) u_route (
        .vld_i  (st_q.vld),
        .data_i (mem_data_i),
        .hot_i  (hot),
        .vld_o  (vld_vec),
        .data_o (dat_vec)
    );

    assign mem_rd_o   = (st_q.phase == PH_ISSUE);
    assign mem_addr_o = st_q.addr;
    assign busy_o     = (st_q.phase != PH_IDLE);
    assign done_o     = st_q.done;

    assign left_valid_o   = vld_vec[0];
    assign left_data_o    = dat_vec[0];
    assign bias_valid_o   = vld_vec[1];
    assign bias_data_o    = dat_vec[1];
    assign target_valid_o = vld_vec[2];
    assign target_data_o  = dat_vec[2];
    assign deriv_valid_o  = vld_vec[3];
    assign deriv_data_o   = dat_vec[3];
    assign bupd_valid_o   = vld_vec[4];
    assign bupd_data_o    = dat_vec[4];
    assign wupd_valid_o   = vld_vec[5];
    assign wupd_data_o    = dat_vec[5];
endmodule

// File: rtl/rs_checker.sv
module rs_checker #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              mem_rd_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              busy_o,
    input logic              done_o,
    input logic [5:0]        valids
);
    assert_valid_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(valids));

    assert_valid_after_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|valids) |-> $past(mem_rd_o));

    assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o && $past(mem_rd_o)) |-> (mem_addr_o == ADDR_W'($past(mem_addr_o) + 1'b1)));

    assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    assert_done_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(busy_o) || $past(start_i)));

    assert_ignore_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(start_i) && $past(mem_rd_o) && mem_rd_o)
            |-> (mem_addr_o == ADDR_W'($past(mem_addr_o) + 1'b1)));
endmodule

bind buf_read_streamer rs_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .mem_rd_o   (mem_rd_o),
    .mem_addr_o (mem_addr_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .valids     ({wupd_valid_o, bupd_valid_o, deriv_valid_o,
                  target_valid_o, bias_valid_o, left_valid_o})
);

// File: tb/buf_read_streamer_tb.sv
module buf_read_streamer_tb;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;
    localparam int ROW_W  = 4;
    localparam int COL_W  = 4;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] base = '0;
    logic [ROW_W-1:0]  rows = '0;
    logic [COL_W-1:0]  cols = '0;
    logic [2:0]        dest = '0;
    logic              mem_rd;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_data = '0;
    logic              busy, done;
    logic              lv, bv, tv, dv, buv, wuv;
    logic [DATA_W-1:0] ld, bd, td, dd, bud, wud;

    logic [DATA_W-1:0] mem [DEPTH];

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    buf_read_streamer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .base_addr_i(base),
        .rows_i(rows), .cols_i(cols), .dest_i(dest),
        .mem_rd_o(mem_rd), .mem_addr_o(mem_addr), .mem_data_i(mem_data),
        .busy_o(busy), .done_o(done),
        .left_valid_o(lv), .left_data_o(ld),
        .bias_valid_o(bv), .bias_data_o(bd),
        .target_valid_o(tv), .target_data_o(td),
        .deriv_valid_o(dv), .deriv_data_o(dd),
        .bupd_valid_o(buv), .bupd_data_o(bud),
        .wupd_valid_o(wuv), .wupd_data_o(wud)
    );

    always_ff @(posedge clk) begin
        if (mem_rd) mem_data <= mem[mem_addr];
    end

    function automatic logic [DATA_W-1:0] word_at(input int a);
        return DATA_W'((a * 97 + 13) ^ (a << 9));
    endfunction

    // consumer port index for a code, -1 when unmapped (R4, R5)
    function automatic int port_of(input logic [2:0] c);
        case (c)
            3'd0: return 0;
            3'd2: return 1;
            3'd3: return 2;
            3'd4: return 3;
            3'd5: return 4;
            3'd6: return 5;
            default: return -1;
        endcase
    endfunction

    function automatic logic [5:0] vvec();
        return {wuv, buv, dv, tv, bv, lv};
    endfunction

    function automatic logic [DATA_W-1:0] dsel(input int p);
        case (p)
            0: return ld;
            1: return bd;
            2: return td;
            3: return dd;
            4: return bud;
            default: return wud;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic xfer(input int b, input int r, input int c, input logic [2:0] d, input bit inject);
        int n = r * c;
        int p = port_of(d);
        logic [5:0] vs;
        bit others_zero;
        @(negedge clk);
        start = 1'b1; base = ADDR_W'(b); rows = ROW_W'(r); cols = COL_W'(c); dest = d;
        @(negedge clk);
        start = 1'b0;
        base = ADDR_W'($urandom); rows = ROW_W'($urandom); cols = COL_W'($urandom); dest = 3'($urandom);
        chk(busy == (n > 0), "R6 busy after start", busy, n > 0);
        chk(done == (n == 0), "R9 done after start", done, n == 0);
        chk(vvec() == 6'b0, "R3 no valid in issue cycle", vvec(), 0);
        if (n == 0) begin
            chk(mem_rd == 1'b0, "R9 no read on zero size", mem_rd, 0);
            return;
        end
        chk(mem_rd && mem_addr == ADDR_W'(b), "R2 first address", mem_addr, ADDR_W'(b));
        for (int j = 1; j <= n + 1; j++) begin
            @(negedge clk);
            vs = vvec();
            others_zero = 1'b1;
            for (int q = 0; q < 6; q++)
                if (q != p && dsel(q) != '0) others_zero = 1'b0;
            if (j <= n) begin
                if (p < 0) begin
                    chk(vs == 6'b0, "R5 unmapped code no valid", vs, 0);
                end else begin
                    chk(vs == 6'(1 << p), "R4 valid on selected port only", vs, 1 << p);
                    chk(dsel(p) == word_at((b + j - 1) % DEPTH), "R3 data word",
                        dsel(p), word_at((b + j - 1) % DEPTH));
                end
                chk(others_zero, "R4 unselected data zero", 0, 0);
                chk(busy && !done, "R6 busy through last word", {busy, done}, 2'b10);
            end else begin
                chk(vs == 6'b0, "R2 word count", vs, 0);
                chk(done && !busy, "R6 done after last word", {busy, done}, 2'b01);
            end
            start = inject && (j == 1);
            if (start) begin
                base = ADDR_W'($urandom); rows = ROW_W'($urandom % 15 + 1);
                cols = COL_W'($urandom % 15 + 1); dest = 3'($urandom);
            end
        end
        start = 1'b0;
        @(negedge clk);
        chk(!done && !busy, "R6 done single cycle", {busy, done}, 0);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = word_at(i);
        void'($urandom(32'h1F2E3D4C));
        repeat (3) @(negedge clk);
        chk(!busy && !done && !mem_rd && vvec() == 6'b0, "R1 reset state",
            {busy, done, mem_rd, vvec()}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        xfer(16, 4, 2, 3'd0, 1'b0);
        xfer(29, 4, 1, 3'd4, 1'b0);
        xfer(21, 4, 2, 3'd2, 1'b0);
        xfer(40, 2, 3, 3'd3, 1'b0);
        xfer(60, 1, 1, 3'd5, 1'b0);
        xfer(70, 3, 3, 3'd6, 1'b0);
        xfer(80, 2, 2, 3'd1, 1'b0);   // R5
        xfer(90, 2, 2, 3'd7, 1'b0);   // R5
        xfer(250, 3, 4, 3'd2, 1'b0);  // R2 wrap
        xfer(5, 0, 3, 3'd0, 1'b0);    // R9
        xfer(5, 3, 0, 3'd0, 1'b0);    // R9
        xfer(100, 4, 4, 3'd3, 1'b1);  // R7 R8
        xfer(120, 1, 2, 3'd6, 1'b1);  // R7
        for (int k = 0; k < 30; k++)
            xfer($urandom % DEPTH, $urandom % 16, $urandom % 16, 3'($urandom), bit'($urandom));
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule